// File: doc/BRIEF.md
# Saturating Accumulator with Rounding

This block keeps two independent 40-bit signed accumulators, A and B, for a signal-processing datapath. On each valid strobe the selected accumulator takes a new value: a sign-extended 32-bit fractional product, or the other accumulator, is added or subtracted. Eight guard bits sit above the 1.31 fraction, so partial sums can leave the fraction range and later return to it without loss.

The result then passes through saturation logic. Three modes are available: clamp to the 1.31 range, clamp to the full 40-bit range, or wrap with no clamping. Each accumulator has a guard overflow flag and a sticky saturation flag. The sticky flag stays set until the matching clear input is pulsed. When rounding is requested, the block also produces a rounded 16-bit high word from the updated value. The rounding mode is either conventional or convergent (round half to even).

Top module: `sat_round_acc`

## Requirements
- R1: While rst_n is low, and after it returns high, both accumulators, rnd_word and all four flags read zero.
- R2: A cycle with in_valid high updates only the accumulator picked by acc_sel (0 = A, 1 = B), and the change is visible one clock later. op_kind 00 adds the sign-extended 32-bit operand and op_kind 01 subtracts it. A cycle with in_valid low leaves both accumulators unchanged.
- R3: op_kind 10 adds the other accumulator to the selected one, and op_kind 11 subtracts it. In both cases the operand input is ignored.
- R4: With sat_en = 1 and sat_super = 0, a result above 0x007FFFFFFF loads 0x007FFFFFFF. A result below 0xFF80000000 (as a 40-bit signed value) loads 0xFF80000000.
- R5: With sat_en = 1 and sat_super = 1, a result outside the 40-bit signed range loads 0x7FFFFFFFFF if it is positive, or 0x8000000000 if it is negative.
- R6: With sat_en = 0 the result wraps modulo 2^40, whatever sat_super is, and it does not set a saturation flag.
- R7: ovf_a (and ovf_b) is high exactly when bits 39..31 of that accumulator are not all equal. This means the value has left the 1.31 range and entered the guard bits.
- R8: sat_a (and sat_b) is set by any update that clamps that accumulator, and it holds until clr_sat_a (clr_sat_b) is high on a clock edge. If a clamp and a clear arrive in the same cycle, the flag ends up set.
- R9: When round_conv = 0, rnd_word takes bits 31..16 of the new value, plus one if bit 15 is 1, modulo 2^16.
- R10: When round_conv = 1, rnd_word takes bits 31..16 of the new value, plus one if bits 15..0 exceed 0x8000. When bits 15..0 equal exactly 0x8000, one is added only if bit 16 is 1.
- R11: rnd_word changes only on cycles where in_valid and round_req are both high. It is computed from the updated value of the selected accumulator, and otherwise it holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation strobe |
| acc_sel | input | 1 | Target accumulator: 0 = A, 1 = B |
| op_kind | input | 2 | 00 add operand, 01 subtract operand, 10 add other, 11 subtract other |
| operand | input | 32 | Signed 1.31 product |
| sat_en | input | 1 | Saturation enable |
| sat_super | input | 1 | 1 = clamp at 40-bit limits, 0 = clamp at 1.31 limits |
| round_req | input | 1 | Produce a rounded word this cycle |
| round_conv | input | 1 | 1 = convergent, 0 = conventional rounding |
| clr_sat_a | input | 1 | Clear sticky saturation flag of A |
| clr_sat_b | input | 1 | Clear sticky saturation flag of B |
| acc_a | output | 40 | Accumulator A |
| acc_b | output | 40 | Accumulator B |
| rnd_word | output | 16 | Rounded high word |
| ovf_a | output | 1 | A has entered its guard bits |
| ovf_b | output | 1 | B has entered its guard bits |
| sat_a | output | 1 | Sticky saturation flag of A |
| sat_b | output | 1 | Sticky saturation flag of B |

## Verification
Every piece of state in this block is an output, so a bad accumulator value or a wrong flag shows at the ports one clock after the strobe that caused it. A wrong sum, clamp limit or wrap stays wrong in later cycles and spreads to the other accumulator through the cross-accumulator operations. A rounding error shows only in rnd_word, and only on cycles that request rounding. For that reason the tie and near-tie low words are driven in both rounding modes. The sticky flags are checked across idle cycles, after clear pulses, and in the cycle where a clamp and a clear collide.

// File: rtl/sat_round_acc.sv
module sat_round_acc #(
  parameter int ACC_W = 40,
  parameter int OPD_W = 32,
  parameter int RND_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             acc_sel,
  input  logic [1:0]       op_kind,
  input  logic [OPD_W-1:0] operand,
  input  logic             sat_en,
  input  logic             sat_super,
  input  logic             round_req,
  input  logic             round_conv,
  input  logic             clr_sat_a,
  input  logic             clr_sat_b,
  output logic [ACC_W-1:0] acc_a,
  output logic [ACC_W-1:0] acc_b,
  output logic [RND_W-1:0] rnd_word,
  output logic             ovf_a,
  output logic             ovf_b,
  output logic             sat_a,
  output logic             sat_b
);
  localparam int GRD_W = ACC_W - OPD_W;
  localparam int FMSB  = OPD_W - 1;
  localparam int RLSB  = OPD_W - RND_W;

  localparam logic [ACC_W-1:0] POS_FR = {{(GRD_W+1){1'b0}}, {FMSB{1'b1}}};
  localparam logic [ACC_W-1:0] NEG_FR = {{(GRD_W+1){1'b1}}, {FMSB{1'b0}}};
  localparam logic [ACC_W-1:0] POS_FL = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic [ACC_W-1:0] NEG_FL = {1'b1, {(ACC_W-1){1'b0}}};

  logic [ACC_W-1:0] cur, oth, src, nxt;
  logic [ACC_W:0]   sum;
  logic             out_fr, out_fl, clamp_fr, clamp_fl, clamp;
  logic [RLSB-1:0]  lo;
  logic [RND_W-1:0] hi;
  logic             inc;

  assign cur = acc_sel ? acc_b : acc_a;
  assign oth = acc_sel ? acc_a : acc_b;
  assign src = op_kind[1] ? oth : {{GRD_W{operand[FMSB]}}, operand};
  assign sum = op_kind[0] ? ({cur[ACC_W-1], cur} - {src[ACC_W-1], src})
                          : ({cur[ACC_W-1], cur} + {src[ACC_W-1], src});

  assign out_fr   = ~((&sum[ACC_W:FMSB]) | ~(|sum[ACC_W:FMSB]));
  assign out_fl   = sum[ACC_W] ^ sum[ACC_W-1];
  assign clamp_fr = sat_en & ~sat_super & out_fr;
  assign clamp_fl = sat_en & sat_super & out_fl;
  assign clamp    = clamp_fr | clamp_fl;

  always_comb begin
    if (clamp_fr)      nxt = sum[ACC_W] ? NEG_FR : POS_FR;
    else if (clamp_fl) nxt = sum[ACC_W] ? NEG_FL : POS_FL;
    else               nxt = sum[ACC_W-1:0];
  end

  assign lo  = nxt[RLSB-1:0];
  assign hi  = nxt[FMSB:RLSB];
  assign inc = round_conv ? (lo[RLSB-1] & ((|lo[RLSB-2:0]) | hi[0])) : lo[RLSB-1];

  wire upd_a = in_valid & ~acc_sel;
  wire upd_b = in_valid & acc_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_a    <= '0;
      acc_b    <= '0;
      rnd_word <= '0;
      sat_a    <= 1'b0;
      sat_b    <= 1'b0;
    end else begin
      if (upd_a) acc_a <= nxt;
      if (upd_b) acc_b <= nxt;
      if (in_valid && round_req) rnd_word <= hi + {{(RND_W-1){1'b0}}, inc};
      sat_a <= (upd_a & clamp) | (sat_a & ~clr_sat_a);
      sat_b <= (upd_b & clamp) | (sat_b & ~clr_sat_b);
    end
  end

  assign ovf_a = ~((&acc_a[ACC_W-1:FMSB]) | ~(|acc_a[ACC_W-1:FMSB]));
  assign ovf_b = ~((&acc_b[ACC_W-1:FMSB]) | ~(|acc_b[ACC_W-1:FMSB]));
endmodule

module sat_round_acc_chk #(
  parameter int ACC_W = 40,
  parameter int OPD_W = 32,
  parameter int RND_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             acc_sel,
  input logic             sat_en,
  input logic             sat_super,
  input logic             round_req,
  input logic             clr_sat_a,
  input logic             clr_sat_b,
  input logic [ACC_W-1:0] acc_a,
  input logic [ACC_W-1:0] acc_b,
  input logic [RND_W-1:0] rnd_word,
  input logic             ovf_a,
  input logic             ovf_b,
  input logic             sat_a,
  input logic             sat_b
);
  localparam int GRD_W = ACC_W - OPD_W;
  localparam logic [ACC_W-1:0] P32 = {{(GRD_W+1){1'b0}}, {(OPD_W-1){1'b1}}};
  localparam logic [ACC_W-1:0] N32 = {{(GRD_W+1){1'b1}}, {(OPD_W-1){1'b0}}};
  localparam logic [ACC_W-1:0] P40 = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic [ACC_W-1:0] N40 = {1'b1, {(ACC_W-1){1'b0}}};

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> $stable(acc_a) && $stable(acc_b)); // R2
  AST_OTHER_HOLD_A: assert property (@(posedge clk) disable iff (!rst_n) (in_valid && !acc_sel) |=> $stable(acc_b)); // R2
  AST_OTHER_HOLD_B: assert property (@(posedge clk) disable iff (!rst_n) (in_valid && acc_sel) |=> $stable(acc_a)); // R2
  AST_FRAC_FIT_A: assert property (@(posedge clk) disable iff (!rst_n) (in_valid && !acc_sel && sat_en && !sat_super) |=> !ovf_a); // R4
  AST_FRAC_FIT_B: assert property (@(posedge clk) disable iff (!rst_n) (in_valid && acc_sel && sat_en && !sat_super) |=> !ovf_b); // R4
  AST_STICKY_A: assert property (@(posedge clk) disable iff (!rst_n) (sat_a && !clr_sat_a) |=> sat_a); // R8
  AST_STICKY_B: assert property (@(posedge clk) disable iff (!rst_n) (sat_b && !clr_sat_b) |=> sat_b); // R8
  AST_SAT_LIMIT_A: assert property (@(posedge clk) disable iff (!rst_n) $rose(sat_a) |-> (acc_a == P32 || acc_a == N32 || acc_a == P40 || acc_a == N40)); // R8
  AST_SAT_LIMIT_B: assert property (@(posedge clk) disable iff (!rst_n) $rose(sat_b) |-> (acc_b == P32 || acc_b == N32 || acc_b == P40 || acc_b == N40)); // R8
  AST_RND_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !(in_valid && round_req) |=> $stable(rnd_word)); // R11
endmodule

bind sat_round_acc sat_round_acc_chk #(.ACC_W(ACC_W), .OPD_W(OPD_W), .RND_W(RND_W)) u_chk (.*);

// File: tb/sat_round_acc_test.sv
module sat_round_acc_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, acc_sel = 1'b0;
  logic [1:0]  op_kind = 2'b00;
  logic [31:0] operand = '0;
  logic        sat_en = 1'b0, sat_super = 1'b0, round_req = 1'b0, round_conv = 1'b0;
  logic        clr_sat_a = 1'b0, clr_sat_b = 1'b0;
  logic [39:0] acc_a, acc_b;
  logic [15:0] rnd_word;
  logic        ovf_a, ovf_b, sat_a, sat_b;

  sat_round_acc uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .acc_sel(acc_sel), .op_kind(op_kind),
    .operand(operand), .sat_en(sat_en), .sat_super(sat_super), .round_req(round_req),
    .round_conv(round_conv), .clr_sat_a(clr_sat_a), .clr_sat_b(clr_sat_b),
    .acc_a(acc_a), .acc_b(acc_b), .rnd_word(rnd_word), .ovf_a(ovf_a), .ovf_b(ovf_b),
    .sat_a(sat_a), .sat_b(sat_b));

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    logic [39:0] a, b;
    logic [15:0] r;
    logic oa, ob, sa, sb;
    string tag;
  } exp_t;

  exp_t q[$];
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  longint ma, mb;
  logic [15:0] mr;
  logic msa, msb;

  localparam longint P32 = 64'sd2147483647;
  localparam longint N32 = -64'sd2147483648;
  localparam longint P40 = (64'sd1 <<< 39) - 1;
  localparam longint N40 = -(64'sd1 <<< 39);

  function automatic longint sx40(logic [39:0] v);
    return $signed({{24{v[39]}}, v});
  endfunction

  function automatic logic [15:0] rnd_model(logic [39:0] v, logic conv);
    logic [15:0] lo, hi;
    lo = v[15:0];
    hi = v[31:16];
    if (!conv) return hi + ((lo >= 16'h8000) ? 16'd1 : 16'd0);
    if (lo > 16'h8000) return hi + 16'd1;
    if (lo == 16'h8000) return hi + {15'd0, hi[0]};
    return hi;
  endfunction

  function automatic logic fr_out(longint v);
    return (v > P32) || (v < N32);
  endfunction

  task automatic check(string what, string tag, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic exp_t snap(string tag);
    exp_t e;
    e.a = ma[39:0]; e.b = mb[39:0]; e.r = mr;
    e.oa = fr_out(ma); e.ob = fr_out(mb); e.sa = msa; e.sb = msb;
    e.tag = tag;
    return e;
  endfunction

  task automatic issue(logic v, logic sel, logic [1:0] k, logic [31:0] opd,
                       logic se, logic ss, logic rr, logic rc,
                       logic ca, logic cb, string tag);
    longint cur, src, tru, res;
    logic cl;
    @(negedge clk);
    in_valid = v; acc_sel = sel; op_kind = k; operand = opd;
    sat_en = se; sat_super = ss; round_req = rr; round_conv = rc;
    clr_sat_a = ca; clr_sat_b = cb;
    cl = 1'b0;
    if (v) begin
      cur = sel ? mb : ma;
      src = k[1] ? (sel ? ma : mb) : longint'($signed(opd));
      tru = k[0] ? cur - src : cur + src;
      res = sx40(tru[39:0]);
      if (se && !ss) begin
        if (tru > P32) begin res = P32; cl = 1'b1; end
        else if (tru < N32) begin res = N32; cl = 1'b1; end
      end else if (se && ss) begin
        if (tru > P40) begin res = P40; cl = 1'b1; end
        else if (tru < N40) begin res = N40; cl = 1'b1; end
      end
      if (sel) mb = res; else ma = res;
      if (rr) mr = rnd_model(res[39:0], rc);
    end
    msa = (v && !sel && cl) || (msa && !ca);
    msb = (v && sel && cl) || (msb && !cb);
    @(posedge clk);
    q.push_back(snap(tag));
  endtask

  task automatic idle(string tag);
    issue(0, 0, 2'b00, 32'h0, 0, 0, 0, 0, 0, 0, tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    in_valid = 0; round_req = 0; clr_sat_a = 0; clr_sat_b = 0;
    rst_n = 0;
    ma = 0; mb = 0; mr = 0; msa = 0; msb = 0;
    #1;
    check("acc_a", "R1", acc_a, 0);
    check("acc_b", "R1", acc_b, 0);
    check("rnd_word", "R1", rnd_word, 0);
    check("flags", "R1", {ovf_a, ovf_b, sat_a, sat_b}, 0);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("acc_a", "R1", acc_a, 0);
    check("flags", "R1", {ovf_a, ovf_b, sat_a, sat_b}, 0);
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        e = q.pop_front();
        check("acc_a", e.tag, acc_a, e.a);
        check("acc_b", e.tag, acc_b, e.b);
        check("rnd_word", e.tag, rnd_word, e.r);
        check("ovf_a", e.tag, ovf_a, e.oa);
        check("ovf_b", e.tag, ovf_b, e.ob);
        check("sat_a", e.tag, sat_a, e.sa);
        check("sat_b", e.tag, sat_b, e.sb);
      end
    end
  end

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    ma = 0; mb = 0; mr = 0; msa = 0; msb = 0;
    repeat (2) @(negedge clk);
    do_reset();

    issue(1, 0, 2'b00, 32'h4000_0000, 0, 0, 0, 0, 0, 0, "R2");
    issue(1, 1, 2'b01, 32'h2000_0000, 0, 0, 0, 0, 0, 0, "R2");
    idle("R2");
    issue(1, 0, 2'b00, 32'hF000_0000, 0, 0, 0, 0, 0, 0, "R2");
    issue(1, 0, 2'b00, 32'h1000_0000, 0, 0, 0, 0, 0, 0, "R2");
    issue(1, 0, 2'b10, 32'hDEAD_BEEF, 0, 0, 0, 0, 0, 0, "R3");
    issue(1, 1, 2'b11, 32'h1234_5678, 0, 0, 0, 0, 0, 0, "R3");

    issue(1, 0, 2'b00, 32'h7FFF_FFFF, 1, 0, 0, 0, 0, 0, "R4");
    idle("R8");
    issue(0, 0, 2'b00, 32'h0, 0, 0, 0, 0, 1, 0, "R8");
    issue(1, 1, 2'b00, 32'h8000_0000, 1, 0, 0, 0, 0, 0, "R4");
    issue(1, 1, 2'b00, 32'h8000_0000, 1, 0, 0, 0, 0, 1, "R8");
    issue(0, 0, 2'b00, 32'h0, 0, 0, 0, 0, 0, 1, "R8");

    issue(1, 0, 2'b00, 32'h7FFF_FFFF, 0, 1, 0, 0, 0, 0, "R6");
    issue(1, 0, 2'b11, 32'h0, 0, 0, 0, 0, 0, 0, "R7");
    issue(1, 1, 2'b10, 32'h0, 0, 0, 0, 0, 0, 0, "R7");

    for (int i = 0; i < 300; i++)
      issue(1, 0, 2'b00, 32'h7FFF_FFFF, 1, 1, 0, 0, 0, 0, "R5");
    for (int i = 0; i < 300; i++)
      issue(1, 1, 2'b01, 32'h7FFF_FFFF, 1, 1, 0, 0, 0, 0, "R5");
    issue(0, 0, 2'b00, 32'h0, 0, 0, 0, 0, 1, 1, "R8");
    issue(1, 0, 2'b00, 32'h0000_0001, 0, 1, 0, 0, 0, 0, "R6");
    issue(1, 1, 2'b01, 32'h0000_0001, 0, 0, 0, 0, 0, 0, "R6");

    idle("R2");
    do_reset();
    issue(1, 0, 2'b00, 32'h1234_8000, 0, 0, 1, 0, 0, 0, "R9");
    issue(1, 0, 2'b00, 32'h0000_0000, 0, 0, 1, 1, 0, 0, "R10");
    issue(1, 0, 2'b00, 32'h0001_0000, 0, 0, 1, 1, 0, 0, "R10");
    issue(1, 0, 2'b00, 32'h0000_0001, 0, 0, 1, 1, 0, 0, "R10");
    issue(1, 0, 2'b01, 32'h0000_0002, 0, 0, 1, 0, 0, 0, "R9");
    issue(1, 0, 2'b00, 32'h0000_0000, 0, 0, 1, 1, 0, 0, "R10");
    issue(1, 0, 2'b00, 32'h0000_0001, 0, 0, 1, 0, 0, 0, "R9");
    issue(1, 0, 2'b00, 32'h0000_0100, 0, 0, 0, 0, 0, 0, "R11");
    idle("R11");
    issue(1, 1, 2'b01, 32'h0000_8000, 0, 0, 1, 0, 0, 0, "R11");
    issue(1, 1, 2'b00, 32'h0000_0000, 0, 0, 1, 1, 0, 0, "R10");
    issue(1, 1, 2'b00, 32'h7FFF_8000, 1, 0, 1, 0, 0, 0, "R9");
    idle("R11");
    idle("R11");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule